// File: doc/BRIEF.md
# Converter Conversion Timing Controller

This block is the digital control half of a successive-approximation converter. It turns the master clock into a slower converter clock through a six-bit prescaler. Each conversion is a sample-and-hold phase of programmable length, followed by a fixed ten-clock conversion phase. The block drives the channel selection and the phase indicators of a converter core, and then captures and formats the core's 12-bit answer.

Software writes a mode word that holds the prescaler value, the sample-hold length, a reduced-resolution bit and a differential bit. The word is only pending when it is written. It is copied into the working configuration at the next accepted start. A start strobe carries a channel number. While a conversion runs, further strobes are ignored. A channel number that the current mode does not allow is refused and an error pulse is raised.

Results are 16-bit words that suit a 16-bit transfer consumer at both resolutions. A last-result register also holds the channel that produced its value. Behind it is one result register per channel, which can be read through an address port.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, done, err, core_sample, core_convert, last_data and last_ch are all zero, and the pending mode is prescaler 0, sample-hold 0, 12-bit, single-ended.
- R2: With D = 2×(prescaler+1) master clocks per converter clock, done rises exactly (shtim+11)×D master clocks after the clock edge that accepts a start. It stays high for one master clock, and busy is high over the whole interval before it.
- R3: Counting from the accepting edge, core_sample is high for the first (shtim+1)×D master clocks and core_convert is high for the next 10×D. The two are never high together.
- R4: In 12-bit mode (lowres=0), last_data equals the core value sampled at the end of the tenth conversion clock, with bits 15:12 zero.
- R5: In reduced mode (lowres=1), last_data[9:0] holds the core value's bits 11:2, and bits 15:10 read zero.
- R6: In single-ended mode (diff=0), channels 0 to 7 are accepted, core_ch equals the channel and core_diff is 0 during the conversion.
- R7: In differential mode (diff=1), pairs 0 to 3 are accepted and core_diff is 1. Channel numbers 4 to 7 start no conversion, and err is high for the single master clock after the refusing edge.
- R8: A start strobe given while busy is high has no effect: no extra conversion, and no change in channel or timing.
- R9: A mode write during a conversion does not change that conversion. It applies from the next accepted start.
- R10: When done rises, last_ch holds the converted channel, and the per-channel register read at rd_ch equal to that channel holds the same word as last_data. Each per-channel register keeps its last result until that channel converts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_prescal | input | 6 | Prescaler value |
| cfg_shtim | input | 4 | Sample-hold length code |
| cfg_lowres | input | 1 | Reduced 10-bit resolution select |
| cfg_diff | input | 1 | Differential input mode select |
| start | input | 1 | Conversion start strobe |
| start_ch | input | 3 | Channel (or pair) for the start |
| core_data | input | 12 | Value returned by the converter core |
| core_ch | output | 3 | Channel presented to the core |
| core_diff | output | 1 | Differential mode presented to the core |
| core_sample | output | 1 | Sample-and-hold phase indicator |
| core_convert | output | 1 | Conversion phase indicator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when results update |
| err | output | 1 | One-clock pulse for a refused channel |
| last_data | output | 16 | Last result word |
| last_ch | output | 3 | Channel of the last result |
| rd_ch | input | 3 | Per-channel result read address |
| rd_data | output | 16 | Per-channel result word |

## Verification
If the accepting edge is counted as cycle 0, the phase indicators are due in every cycle from 0 to (shtim+11)×D−1. Done, last_data, last_ch and rd_data are due in cycle (shtim+11)×D, and err is due in cycle 1 after a refused strobe. Inputs change and outputs are read on the falling edge. The driver compares the phase indicators in every cycle of each conversion, and it pushes the expected due cycle together with the result word into a queue. The monitor compares the master-clock count and the words at the moment done is seen, and it treats a done with an empty queue as a mismatch.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  localparam int PRESC_W    = 6;
  localparam int SHT_W      = 4;
  localparam int RAW_W      = 12;
  localparam int LOW_W      = 10;
  localparam int WORD_W     = 16;
  localparam int NCH        = 8;
  localparam int CH_W       = $clog2(NCH);
  localparam int CONV_TICKS = 10;
  localparam int TCNT_W     = (SHT_W > $clog2(CONV_TICKS)) ? SHT_W : $clog2(CONV_TICKS);

  typedef struct packed {
    logic [PRESC_W-1:0] prescal;
    logic [SHT_W-1:0]   shtim;
    logic               lowres;
    logic               diff;
  } mode_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int PW = sar_ctrl_pkg::PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] prescal,
  output logic          tick
);
  localparam int CW = PW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;

  // one converter clock spans 2*(prescal+1) master clocks
  assign lim = {prescal, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    if (!run)             cnt_d = '0;
    else if (cnt_q == lim) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == lim);

  // R2: converter clock enables are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int NC     = NCH,
  parameter int CW     = CH_W,
  parameter int NTICK  = CONV_TICKS,
  parameter int TW     = TCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_ch,
  input  mode_t         pend,
  input  logic          tick,
  output phase_e        phase,
  output logic          run,
  output logic [CW-1:0] cur_ch,
  output mode_t         shadow,
  output logic          capture,
  output logic          err
);
  localparam logic [CW:0] LIM_SE   = (CW+1)'(NC);
  localparam logic [CW:0] LIM_DIFF = (CW+1)'(NC / 2);
  localparam logic [TW-1:0] LAST_CONV = TW'(NTICK - 1);

  phase_e        phase_q, phase_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [CW-1:0] ch_q, ch_d;
  mode_t         shadow_q, shadow_d;
  logic          err_q, err_d;
  logic [CW:0]   ch_lim;
  logic          ch_ok;
  logic          accept;
  logic          cap_now;

  assign ch_lim = pend.diff ? LIM_DIFF : LIM_SE;
  assign ch_ok  = {1'b0, start_ch} < ch_lim;
  assign accept = (phase_q == PH_IDLE) && start && ch_ok;

  always_comb begin
    phase_d  = phase_q;
    tcnt_d   = tcnt_q;
    ch_d     = ch_q;
    shadow_d = shadow_q;
    cap_now  = 1'b0;
    err_d    = (phase_q == PH_IDLE) && start && !ch_ok;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d  = PH_SAMPLE;
          tcnt_d   = '0;
          ch_d     = start_ch;
          shadow_d = pend;
        end
      end
      PH_SAMPLE: begin
        if (tick) begin
          if (tcnt_q == TW'(shadow_q.shtim)) begin
            phase_d = PH_CONV;
            tcnt_d  = '0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      PH_CONV: begin
        if (tick) begin
          if (tcnt_q == LAST_CONV) begin
            phase_d = PH_IDLE;
            tcnt_d  = '0;
            cap_now = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      tcnt_q   <= '0;
      ch_q     <= '0;
      shadow_q <= '0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      tcnt_q   <= tcnt_d;
      ch_q     <= ch_d;
      shadow_q <= shadow_d;
      err_q    <= err_d;
    end
  end

  assign phase   = phase_q;
  assign run     = (phase_q != PH_IDLE);
  assign cur_ch  = ch_q;
  assign shadow  = shadow_q;
  assign capture = cap_now;
  assign err     = err_q;

  // R8: a strobe during a conversion leaves the channel alone
  a_r8_ch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && start) |=> $stable(ch_q));
  // R9: working configuration frozen while converting
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(shadow_q));
  // R7: a refused strobe never starts a conversion
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> phase_q == PH_IDLE);
  // R7: differential conversions only on the lower half of channels
  a_r7_diff_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && shadow_q.diff) |-> ({1'b0, ch_q} < LIM_DIFF));
  // R3: conversion phase only follows the sample phase
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && $past(phase_q) != PH_CONV) |-> $past(phase_q) == PH_SAMPLE);
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RW  = sar_ctrl_pkg::RAW_W,
  parameter int LW  = sar_ctrl_pkg::LOW_W,
  parameter int WW  = sar_ctrl_pkg::WORD_W,
  parameter int NC  = sar_ctrl_pkg::NCH,
  parameter int CW  = sar_ctrl_pkg::CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [RW-1:0] raw,
  input  logic          lowres,
  input  logic [CW-1:0] cap_ch,
  input  logic [CW-1:0] rd_ch,
  output logic [WW-1:0] last_data,
  output logic [CW-1:0] last_ch,
  output logic          done,
  output logic [WW-1:0] rd_data
);
  localparam int PAD_W = RW - LW;

  logic [RW-1:0] fmt_val;
  logic [RW-1:0] last_q, last_d;
  logic [CW-1:0] lch_q, lch_d;
  logic          done_q;
  logic [RW-1:0] bank [NC];

  // reduced mode keeps the upper LW bits, right aligned
  assign fmt_val = lowres ? {{PAD_W{1'b0}}, raw[RW-1 -: LW]} : raw;

  always_comb begin
    last_d = last_q;
    lch_d  = lch_q;
    if (capture) begin
      last_d = fmt_val;
      lch_d  = cap_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      lch_q  <= '0;
      done_q <= 1'b0;
    end else begin
      last_q <= last_d;
      lch_q  <= lch_d;
      done_q <= capture;
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_bank
    logic [RW-1:0] slot_q;
    logic          slot_en;
    assign slot_en = capture && (cap_ch == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= fmt_val;
    end
    assign bank[g] = slot_q;
  end

  assign last_data = WW'(last_q);
  assign last_ch   = lch_q;
  assign done      = done_q;
  assign rd_data   = WW'(bank[rd_ch]);

  // R5: reduced results have their two upper data bits clear
  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && lowres) |=> last_data[RW-1:LW] == '0);
  // R10: channel bank agrees with the last-result register
  a_r10_bank_match: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_ch == last_ch) |-> rd_data == last_data);
  // R2: done is a single-clock pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [PRESC_W-1:0]  cfg_prescal,
  input  logic [SHT_W-1:0]    cfg_shtim,
  input  logic                cfg_lowres,
  input  logic                cfg_diff,
  input  logic                start,
  input  logic [CH_W-1:0]     start_ch,
  input  logic [RAW_W-1:0]    core_data,
  output logic [CH_W-1:0]     core_ch,
  output logic                core_diff,
  output logic                core_sample,
  output logic                core_convert,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [WORD_W-1:0]   last_data,
  output logic [CH_W-1:0]     last_ch,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [WORD_W-1:0]   rd_data
);
  localparam int LEN_W = $clog2(((1 << SHT_W) + CONV_TICKS + 1) * 2 * (1 << PRESC_W)) + 1;

  logic [1:0] rs_q;
  logic       rst_i;
  mode_t      pend_q, pend_d;
  mode_t      shadow;
  phase_e     phase;
  logic       run, tick, capture;
  logic [CH_W-1:0] cur_ch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    pend_d = pend_q;
    if (cfg_we) begin
      pend_d.prescal = cfg_prescal;
      pend_d.shtim   = cfg_shtim;
      pend_d.lowres  = cfg_lowres;
      pend_d.diff    = cfg_diff;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  sar_clk_div #(.PW(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_i),
    .run     (run),
    .prescal (shadow.prescal),
    .tick    (tick)
  );

  sar_seq #(.NC(NCH), .CW(CH_W), .NTICK(CONV_TICKS), .TW(TCNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (start),
    .start_ch (start_ch),
    .pend     (pend_q),
    .tick     (tick),
    .phase    (phase),
    .run      (run),
    .cur_ch   (cur_ch),
    .shadow   (shadow),
    .capture  (capture),
    .err      (err)
  );

  sar_result #(.RW(RAW_W), .LW(LOW_W), .WW(WORD_W), .NC(NCH), .CW(CH_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_i),
    .capture   (capture),
    .raw       (core_data),
    .lowres    (shadow.lowres),
    .cap_ch    (cur_ch),
    .rd_ch     (rd_ch),
    .last_data (last_data),
    .last_ch   (last_ch),
    .done      (done),
    .rd_data   (rd_data)
  );

  assign core_ch      = cur_ch;
  assign core_diff    = shadow.diff;
  assign core_sample  = (phase == PH_SAMPLE);
  assign core_convert = (phase == PH_CONV);
  assign busy         = run;

  // conversion length watch: cycles spent busy
  logic [LEN_W-1:0] len_q, len_d, len_exp;
  assign len_d   = busy ? len_q + 1'b1 : '0;
  assign len_exp = (LEN_W'(shadow.shtim) + LEN_W'(CONV_TICKS + 1)) *
                   (LEN_W'(shadow.prescal) + LEN_W'(1)) * LEN_W'(2);
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) len_q <= '0;
    else        len_q <= len_d;
  end

  // R2: total length is (shtim+11) converter clocks
  a_r2_length: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(done) |-> len_q == len_exp);
  // R3: sample and convert indicators exclusive, both only while busy
  a_r3_phase_busy: assert property (@(posedge clk) disable iff (!rst_i)
    (core_sample || core_convert) |-> busy && !(core_sample && core_convert));
  // R7: refused strobe raises no busy
  a_r7_err_no_busy: assert property (@(posedge clk) disable iff (!rst_i)
    err |-> !busy);
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_prescal;
  logic [3:0]  cfg_shtim;
  logic        cfg_lowres;
  logic        cfg_diff;
  logic        start;
  logic [2:0]  start_ch;
  logic [11:0] core_data;
  logic [2:0]  core_ch;
  logic        core_diff;
  logic        core_sample;
  logic        core_convert;
  logic        busy;
  logic        done;
  logic        err;
  logic [15:0] last_data;
  logic [2:0]  last_ch;
  logic [2:0]  rd_ch;
  logic [15:0] rd_data;

  sar_conv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prescal(cfg_prescal),
    .cfg_shtim(cfg_shtim), .cfg_lowres(cfg_lowres), .cfg_diff(cfg_diff),
    .start(start), .start_ch(start_ch), .core_data(core_data),
    .core_ch(core_ch), .core_diff(core_diff), .core_sample(core_sample),
    .core_convert(core_convert), .busy(busy), .done(done), .err(err),
    .last_data(last_data), .last_ch(last_ch), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural core: value depends on selection only
  function automatic logic [11:0] core_model(input logic [2:0] c, input logic d);
    return 12'h5A3 ^ {c, d, 8'h3C};
  endfunction
  assign core_data = core_model(core_ch, core_diff);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  typedef struct {
    int          due;
    logic [15:0] data;
    logic [2:0]  ch;
  } exp_t;
  exp_t q[$];
  logic [11:0] bank_exp [8];

  int cp = 0, cs = 0;
  bit clr = 0, cdf = 0;

  // monitor: pops one expectation per done pulse
  exp_t m_e;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk("R2 R8 unexpected done", 1, 0);
      end else begin
        m_e = q.pop_front();
        chk("R2 done cycle", cyc, m_e.due);
        chk("R4 R5 last_data", last_data, m_e.data);
        chk("R10 last_ch", last_ch, m_e.ch);
        chk("R10 rd_data", rd_data, m_e.data);
      end
    end
  end

  task automatic write_cfg(input int p, input int s, input bit lr, input bit df);
    @(negedge clk);
    cfg_we = 1'b1; cfg_prescal = p[5:0]; cfg_shtim = s[3:0];
    cfg_lowres = lr; cfg_diff = df;
    @(negedge clk);
    cfg_we = 1'b0;
    cp = p; cs = s; clr = lr; cdf = df;
  endtask

  task automatic run_conv(input int ch, input string sel_req, input bit poke,
                          input int np, input int ns, input bit nlr, input bit ndf);
    int p = cp, s = cs;
    bit lr = clr, df = cdf;
    int d = 2 * (p + 1);
    int n = (s + 11) * d;
    int bad_ph = 0, bad_sel = 0;
    logic [11:0] raw, fmt;
    exp_t e;
    @(negedge clk);
    start = 1'b1; start_ch = ch[2:0]; rd_ch = ch[2:0];
    @(negedge clk);
    start = 1'b0;
    raw = core_model(ch[2:0], df);
    fmt = lr ? {2'b00, raw[11:2]} : raw;
    e.due = cyc + n; e.data = {4'h0, fmt}; e.ch = ch[2:0];
    q.push_back(e);
    bank_exp[ch] = fmt;
    for (int k = 0; k < n; k++) begin
      if (core_sample  !== (k < (s + 1) * d))  bad_ph++;
      if (core_convert !== (k >= (s + 1) * d)) bad_ph++;
      if (busy !== 1'b1) bad_ph++;
      if (core_ch !== ch[2:0] || core_diff !== df) bad_sel++;
      if (poke && k == 1) begin
        start = 1'b1; start_ch = ch[2:0] ^ 3'd5;
        cfg_we = 1'b1; cfg_prescal = np[5:0]; cfg_shtim = ns[3:0];
        cfg_lowres = nlr; cfg_diff = ndf;
      end
      if (poke && k == 2) begin
        start = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    chk("R3 phase profile", bad_ph, 0);
    chk({sel_req, " core selection"}, bad_sel, 0);
    chk("R2 busy low at done", busy, 0);
    if (poke) begin
      cp = np; cs = ns; clr = nlr; cdf = ndf;
    end
  endtask

  task automatic run_bad(input int ch);
    @(negedge clk);
    start = 1'b1; start_ch = ch[2:0];
    @(negedge clk);
    start = 1'b0;
    chk("R7 err pulse", err, 1);
    chk("R7 no busy on refusal", busy, 0);
    @(negedge clk);
    chk("R7 err one clock", err, 0);
    chk("R7 still idle", busy, 0);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      chk("watchdog", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_prescal = '0; cfg_shtim = '0;
    cfg_lowres = 1'b0; cfg_diff = 1'b0; start = 1'b0; start_ch = '0; rd_ch = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 phases", {core_sample, core_convert}, 0);
    chk("R1 last_data", last_data, 0);
    chk("R1 last_ch", last_ch, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", busy, 0);
    chk("R1 rd_data cleared", rd_data, 0);

    // R4 R6: reset mode, 12-bit single-ended
    run_conv(2, "R6", 0, 0, 0, 0, 0);
    // R5: reduced resolution, slower clock, top channel
    write_cfg(2, 3, 1, 0);
    run_conv(7, "R6", 0, 0, 0, 0, 0);
    // R7: differential pair and refused channels
    write_cfg(1, 1, 0, 1);
    run_conv(3, "R7", 0, 0, 0, 0, 0);
    run_bad(5);
    run_bad(4);
    // R8 R9: strobe and mode write during a conversion
    write_cfg(0, 2, 0, 0);
    run_conv(1, "R8", 1, 3, 0, 1, 0);
    run_conv(6, "R9", 0, 0, 0, 0, 0);
    // R2: largest prescaler and sample-hold
    write_cfg(63, 15, 0, 0);
    run_conv(0, "R2", 0, 0, 0, 0, 0);
    write_cfg(0, 0, 0, 0);
    run_conv(5, "R6", 0, 0, 0, 0, 0);

    // R10: channel bank retains older results
    @(negedge clk);
    rd_ch = 3'd2;
    @(negedge clk);
    chk("R10 bank ch2", rd_data, {4'h0, bank_exp[2]});
    rd_ch = 3'd7;
    @(negedge clk);
    chk("R10 bank ch7", rd_data, {4'h0, bank_exp[7]});
    rd_ch = 3'd3;
    @(negedge clk);
    chk("R10 bank ch3", rd_data, {4'h0, bank_exp[3]});

    repeat (5) @(negedge clk);
    chk("R2 R8 queue drained", q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule